// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash device. It watches bus write cycles, each with an address and a data word. It recognises the short command sequences that open with a fixed two-write unlock pattern. For each command it recognises, it issues a one-clock pulse on that command's own output, together with the address and data it latched. It also keeps track of what a bus read should return: the array contents, the identification data, or the status register.

An abstract array controller reports busy and error. The decoder uses these two inputs to leave status mode when an operation completes. When an operation fails, the decoder holds status mode until a read/reset command arrives. While the controller is busy, command writes are ignored. A streaming multi-word program write that arrives during busy is discarded and raises a sticky sequence-error flag.

Only the low eleven address bits and the low data byte take part in matching. The full-width address and data are still passed out with the command pulses.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Command matching uses only address bits [10:0] and data bits [7:0]. Higher address and data bits never change which command is recognised.
- R2: A single write with data F0 (hex) while idle issues a read/reset pulse, whatever the address. The sequence 555/AA, 2AA/55, 555/F0 also issues a read/reset pulse.
- R3: The sequence 555/AA, 2AA/55, 555/90 issues an auto-select pulse. Read mode then becomes 1 (identification), unless the error hold is set.
- R4: The sequence 555/AA, 2AA/55, 555/A0 followed by one more write issues a program pulse. On that pulse, cmd_addr and cmd_data carry the fourth write's full address and data.
- R5: The sequence 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55 followed by data 30 to any address issues a block-erase pulse. On that pulse, cmd_addr carries the sixth write's address.
- R6: The same five-write erase prefix followed by 555/10 issues a chip-erase pulse. Data 10 written to any other address issues nothing.
- R7: A write that does not fit the current step returns the decoder to idle. No pulse is issued and read mode is left unchanged.
- R8: The sequence 555/AA, 2AA/55, 555/20 opens the multi-word program phase. The first data write issues a word pulse with mwp_first=1. Each later write within the same 2^BLK_LSB-word block issues a word pulse with mwp_first=0. The first write to a different block issues a done pulse instead and ends the phase.
- R9: A program, erase or word pulse sets read mode to 2 (status). When busy falls and err is 0, read mode returns to 0 (array), unless the error hold is set.
- R10: When busy falls and err is 1, read mode becomes 2 and the error hold is set. While the hold is set, an auto-select command does not change the mode. Only a read/reset command returns the mode to 0 and clears the hold.
- R11: While busy is 1, writes issue no pulse and change no sequence state. A multi-word data write during busy is discarded and sets seq_err. seq_err stays set until a read/reset pulse clears it.
- R12: Every command pulse lasts exactly one clock. At most one command pulse is high in any cycle.
- R13: After reset, read mode is 0, seq_err is 0, all pulses are low and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A bus write cycle is present |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Array controller is running an operation |
| err | input | 1 | Array controller's operation failed; sampled when busy falls |
| rd_reset_pulse | output | 1 | Read/reset command recognised |
| autosel_pulse | output | 1 | Auto-select command recognised |
| prog_pulse | output | 1 | Word program command recognised |
| blk_erase_pulse | output | 1 | Block erase command recognised |
| chip_erase_pulse | output | 1 | Chip erase command recognised |
| mwp_word_pulse | output | 1 | Multi-word program data word accepted |
| mwp_first | output | 1 | Marks the first word of the multi-word phase |
| mwp_done_pulse | output | 1 | Multi-word phase ended by its final write |
| cmd_addr | output | ADDR_W | Address latched with the last pulse |
| cmd_data | output | DATA_W | Data latched with the last pulse |
| read_mode | output | 2 | 0 array, 1 identification, 2 status |
| seq_err | output | 1 | Sticky multi-word sequence error |

## Verification
Two functions can act on the same read-mode decision: the sticky error hold, set when busy falls with err high, and a fresh auto-select command. The bench ends a block erase with err raised and then issues a full auto-select sequence. It checks that the auto-select pulse still appears while read mode stays at status, and that only a later read/reset returns the mode to array. A second such meeting sets seq_err with a word written during busy, then clears it with the read/reset pulse that ends the multi-word test. Both the flag and the pulse are checked at the same sample.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int MATCH_AW = 11;
    localparam int MATCH_DW = 8;

    localparam logic [MATCH_AW-1:0] A_KEY1 = 11'h555;
    localparam logic [MATCH_AW-1:0] A_KEY2 = 11'h2AA;

    localparam logic [MATCH_DW-1:0] D_KEY1    = 8'hAA;
    localparam logic [MATCH_DW-1:0] D_KEY2    = 8'h55;
    localparam logic [MATCH_DW-1:0] D_RESET   = 8'hF0;
    localparam logic [MATCH_DW-1:0] D_IDENT   = 8'h90;
    localparam logic [MATCH_DW-1:0] D_PROG    = 8'hA0;
    localparam logic [MATCH_DW-1:0] D_ERASE   = 8'h80;
    localparam logic [MATCH_DW-1:0] D_STREAM  = 8'h20;
    localparam logic [MATCH_DW-1:0] D_BLK     = 8'h30;
    localparam logic [MATCH_DW-1:0] D_CHIP    = 8'h10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_KEY1,
        S_KEY2,
        S_PROG,
        S_ER_SETUP,
        S_ER_KEY1,
        S_ER_KEY2,
        S_STR_FIRST,
        S_STR_NEXT
    } seq_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } read_mode_e;

    // Classification of one write, from the low address and data bits only
    typedef struct packed {
        logic key1;
        logic key2;
        logic at_cmd;
        logic d_reset;
        logic d_ident;
        logic d_prog;
        logic d_erase;
        logic d_stream;
        logic d_blk;
        logic d_chip;
    } wr_class_t;

    // One bit per command pulse
    typedef struct packed {
        logic str_done;
        logic str_word;
        logic chip_erase;
        logic blk_erase;
        logic prog;
        logic ident;
        logic rd_reset;
    } cmd_pulse_t;

    function automatic logic is_pair(
        input logic [MATCH_AW-1:0] a, input logic [MATCH_DW-1:0] d,
        input logic [MATCH_AW-1:0] ea, input logic [MATCH_DW-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic logic starts_status(input cmd_pulse_t p);
        return p.prog | p.blk_erase | p.chip_erase | p.str_word;
    endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
(
    input  logic [MATCH_AW-1:0] addr_lo,
    input  logic [MATCH_DW-1:0] data_lo,
    output wr_class_t           cls
);
    always_comb begin
        cls.key1     = is_pair(addr_lo, data_lo, A_KEY1, D_KEY1);
        cls.key2     = is_pair(addr_lo, data_lo, A_KEY2, D_KEY2);
        cls.at_cmd   = (addr_lo == A_KEY1);
        cls.d_reset  = (data_lo == D_RESET);
        cls.d_ident  = (data_lo == D_IDENT);
        cls.d_prog   = (data_lo == D_PROG);
        cls.d_erase  = (data_lo == D_ERASE);
        cls.d_stream = (data_lo == D_STREAM);
        cls.d_blk    = (data_lo == D_BLK);
        cls.d_chip   = (data_lo == D_CHIP);
    end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int BLK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  wr_class_t         cls,
    output cmd_pulse_t        pulse,
    output logic              first_word,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              stream_err
);
    localparam int BLK_W = ADDR_W - BLK_LSB;

    seq_state_e       state;
    logic [BLK_W-1:0] str_blk;
    logic             in_stream;
    logic             new_blk;

    assign in_stream = (state == S_STR_FIRST) || (state == S_STR_NEXT);
    assign new_blk   = (wr_addr[ADDR_W-1:BLK_LSB] != str_blk);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            pulse      <= '0;
            first_word <= 1'b0;
            lat_addr   <= '0;
            lat_data   <= '0;
            stream_err <= 1'b0;
            str_blk    <= '0;
        end else begin
            pulse      <= '0;
            first_word <= 1'b0;
            if (wr_en && busy) begin
                if (in_stream) begin
                    stream_err <= 1'b1;
                end
            end else if (wr_en) begin
                case (state)
                    S_IDLE: begin
                        if (cls.key1) begin
                            state <= S_KEY1;
                        end else if (cls.d_reset) begin
                            pulse.rd_reset <= 1'b1;
                            stream_err     <= 1'b0;
                        end
                    end
                    S_KEY1: state <= cls.key2 ? S_KEY2 : S_IDLE;
                    S_KEY2: begin
                        state <= S_IDLE;
                        if (cls.at_cmd) begin
                            if (cls.d_reset) begin
                                pulse.rd_reset <= 1'b1;
                                stream_err     <= 1'b0;
                            end else if (cls.d_ident) begin
                                pulse.ident <= 1'b1;
                            end else if (cls.d_prog) begin
                                state <= S_PROG;
                            end else if (cls.d_erase) begin
                                state <= S_ER_SETUP;
                            end else if (cls.d_stream) begin
                                state <= S_STR_FIRST;
                            end
                        end
                    end
                    S_PROG: begin
                        state      <= S_IDLE;
                        pulse.prog <= 1'b1;
                        lat_addr   <= wr_addr;
                        lat_data   <= wr_data;
                    end
                    S_ER_SETUP: state <= cls.key1 ? S_ER_KEY1 : S_IDLE;
                    S_ER_KEY1:  state <= cls.key2 ? S_ER_KEY2 : S_IDLE;
                    S_ER_KEY2: begin
                        state <= S_IDLE;
                        if (cls.d_blk) begin
                            pulse.blk_erase <= 1'b1;
                            lat_addr        <= wr_addr;
                            lat_data        <= wr_data;
                        end else if (cls.d_chip && cls.at_cmd) begin
                            pulse.chip_erase <= 1'b1;
                            lat_addr         <= wr_addr;
                            lat_data         <= wr_data;
                        end
                    end
                    S_STR_FIRST: begin
                        state          <= S_STR_NEXT;
                        pulse.str_word <= 1'b1;
                        first_word     <= 1'b1;
                        lat_addr       <= wr_addr;
                        lat_data       <= wr_data;
                        str_blk        <= wr_addr[ADDR_W-1:BLK_LSB];
                    end
                    S_STR_NEXT: begin
                        lat_addr <= wr_addr;
                        lat_data <= wr_data;
                        if (new_blk) begin
                            state          <= S_IDLE;
                            pulse.str_done <= 1'b1;
                        end else begin
                            pulse.str_word <= 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  logic       err,
    input  cmd_pulse_t pulse,
    output read_mode_e mode
);
    logic busy_q;
    logic err_hold;
    logic done_evt;

    assign done_evt = busy_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= RM_ARRAY;
            busy_q   <= 1'b0;
            err_hold <= 1'b0;
        end else begin
            busy_q <= busy;
            if (pulse.rd_reset) begin
                mode     <= RM_ARRAY;
                err_hold <= 1'b0;
            end else if (done_evt) begin
                if (err) begin
                    mode     <= RM_STATUS;
                    err_hold <= 1'b1;
                end else if (!err_hold) begin
                    mode <= RM_ARRAY;
                end
            end else if (starts_status(pulse)) begin
                mode <= RM_STATUS;
            end else if (pulse.ident && !err_hold) begin
                mode <= RM_IDENT;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int BLK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              err,
    output logic              rd_reset_pulse,
    output logic              autosel_pulse,
    output logic              prog_pulse,
    output logic              blk_erase_pulse,
    output logic              chip_erase_pulse,
    output logic              mwp_word_pulse,
    output logic              mwp_first,
    output logic              mwp_done_pulse,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [1:0]        read_mode,
    output logic              seq_err
);
    wr_class_t  cls;
    cmd_pulse_t pulse;
    read_mode_e mode;

    fcd_classify u_cls (
        .addr_lo (wr_addr[MATCH_AW-1:0]),
        .data_lo (wr_data[MATCH_DW-1:0]),
        .cls     (cls)
    );

    fcd_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BLK_LSB (BLK_LSB)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .cls        (cls),
        .pulse      (pulse),
        .first_word (mwp_first),
        .lat_addr   (cmd_addr),
        .lat_data   (cmd_data),
        .stream_err (seq_err)
    );

    fcd_mode u_mode (
        .clk   (clk),
        .rst   (rst),
        .busy  (busy),
        .err   (err),
        .pulse (pulse),
        .mode  (mode)
    );

    assign rd_reset_pulse   = pulse.rd_reset;
    assign autosel_pulse    = pulse.ident;
    assign prog_pulse       = pulse.prog;
    assign blk_erase_pulse  = pulse.blk_erase;
    assign chip_erase_pulse = pulse.chip_erase;
    assign mwp_word_pulse   = pulse.str_word;
    assign mwp_done_pulse   = pulse.str_done;
    assign read_mode        = mode;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       rd_reset_pulse,
    input logic       autosel_pulse,
    input logic       prog_pulse,
    input logic       blk_erase_pulse,
    input logic       chip_erase_pulse,
    input logic       mwp_word_pulse,
    input logic       mwp_done_pulse,
    input logic [1:0] read_mode,
    input logic       seq_err
);
    // R12
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_reset_pulse, autosel_pulse, prog_pulse, blk_erase_pulse,
                  chip_erase_pulse, mwp_word_pulse, mwp_done_pulse}));

    // R12
    prog_single_chk: assert property (@(posedge clk) disable iff (rst)
        prog_pulse |=> !prog_pulse);

    // R9
    prog_status_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_pulse && !($past(busy) && !busy)) |=> (read_mode == 2'd2));

    // R13
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (read_mode == 2'd0 && !seq_err && !prog_pulse && !rd_reset_pulse));

    // R11
    seq_err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> $past(busy));
endmodule

bind flash_cmd_decoder fcd_checker u_fcd_chk (
    .clk              (clk),
    .rst              (rst),
    .busy             (busy),
    .rd_reset_pulse   (rd_reset_pulse),
    .autosel_pulse    (autosel_pulse),
    .prog_pulse       (prog_pulse),
    .blk_erase_pulse  (blk_erase_pulse),
    .chip_erase_pulse (chip_erase_pulse),
    .mwp_word_pulse   (mwp_word_pulse),
    .mwp_done_pulse   (mwp_done_pulse),
    .read_mode        (read_mode),
    .seq_err          (seq_err)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int NV = 34;

    // {addr[23:0], data[15:0], expected pulses[7:0]}
    // pulse bits: [6] done [5] word [4] chip [3] blk [2] prog [1] ident [0] reset
    localparam logic [47:0] VEC [NV] = '{
        48'h03ABCD_12F0_01,                                       // R1 R2
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000555_0090_02, // R3
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000555_00F0_01, // R2
        48'h3FD555_FFAA_00, 48'h01FAAA_3355_00, 48'h000555_00A0_00,
        48'h012345_BEEF_04,                                       // R1 R4
        48'h000555_00AA_00, 48'h000123_0055_00, 48'h0002AA_0055_00,
        48'h000555_00A0_00, 48'h000010_1111_00,                   // R7
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000555_0080_00,
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000555_0010_10, // R6
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000555_0080_00,
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h024000_0030_08, // R5
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000555_0080_00,
        48'h000555_00AA_00, 48'h0002AA_0055_00, 48'h000556_0010_00  // R6
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          err = 1'b0;
    logic          rd_reset_pulse, autosel_pulse, prog_pulse, blk_erase_pulse;
    logic          chip_erase_pulse, mwp_word_pulse, mwp_first, mwp_done_pulse;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [1:0]    read_mode;
    logic          seq_err;
    logic [6:0]    pulses;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    assign pulses = {mwp_done_pulse, mwp_word_pulse, chip_erase_pulse, blk_erase_pulse,
                     prog_pulse, autosel_pulse, rd_reset_pulse};

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .busy, .err,
        .rd_reset_pulse, .autosel_pulse, .prog_pulse, .blk_erase_pulse,
        .chip_erase_pulse, .mwp_word_pulse, .mwp_first, .mwp_done_pulse,
        .cmd_addr, .cmd_data, .read_mode, .seq_err
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write; returns at the negedge after the capturing edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check("R13 mode", 32'(read_mode), 32'd0);
        check("R13 seq_err", 32'(seq_err), 32'd0);
        check("R13 pulses", 32'(pulses), 32'd0);

        // table walk: R1..R7
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][45:24], VEC[i][23:8]);
            check($sformatf("R1-table vec%0d pulses", i), 32'(pulses), 32'(VEC[i][6:0]));
        end
        @(negedge clk);

        // R4 latch, R9 status then completion
        unlock();
        wr(22'h555, 16'h00A0);
        wr(22'h1F00A, 16'hA5C3);
        check("R4 prog pulse", 32'(prog_pulse), 32'd1);
        check("R4 cmd_addr", 32'(cmd_addr), 32'h1F00A);
        check("R4 cmd_data", 32'(cmd_data), 32'hA5C3);
        @(negedge clk);
        check("R9 status after prog", 32'(read_mode), 32'd2);
        busy = 1'b1;
        wr(22'h0, 16'h00F0);
        check("R11 reset ignored while busy", 32'(pulses), 32'd0);
        unlock();
        wr(22'h555, 16'h0090);
        check("R11 ident ignored while busy", 32'(pulses), 32'd0);
        check("R11 no seq_err outside stream", 32'(seq_err), 32'd0);
        busy = 1'b0;
        @(negedge clk);
        check("R9 array after good completion", 32'(read_mode), 32'd0);

        // R5 latch, R10 sticky error
        unlock();
        wr(22'h555, 16'h0080);
        unlock();
        wr(22'h25432, 16'h0030);
        check("R5 blk pulse", 32'(blk_erase_pulse), 32'd1);
        check("R5 cmd_addr", 32'(cmd_addr), 32'h25432);
        busy = 1'b1;
        repeat (3) @(negedge clk);
        err  = 1'b1;
        busy = 1'b0;
        @(negedge clk);
        err = 1'b0;
        check("R10 status on error", 32'(read_mode), 32'd2);
        unlock();
        wr(22'h555, 16'h0090);
        check("R10 ident pulse during hold", 32'(autosel_pulse), 32'd1);
        @(negedge clk);
        check("R10 mode held at status", 32'(read_mode), 32'd2);
        wr(22'h777, 16'h00F0);
        @(negedge clk);
        check("R10 reset returns array", 32'(read_mode), 32'd0);

        // R3 ident mode, R7 abort keeps mode
        unlock();
        wr(22'h555, 16'h0090);
        @(negedge clk);
        check("R3 ident mode", 32'(read_mode), 32'd1);
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0000);
        @(negedge clk);
        check("R7 abort leaves mode", 32'(read_mode), 32'd1);
        check("R7 abort no pulse", 32'(pulses), 32'd0);
        wr(22'h0, 16'h00F0);

        // R8 stream with R11 busy word
        unlock();
        wr(22'h555, 16'h0020);
        check("R8 setup no pulse", 32'(pulses), 32'd0);
        wr(22'h30010, 16'h1111);
        check("R8 first word pulse", 32'(pulses), 32'h20);
        check("R8 first flag", 32'(mwp_first), 32'd1);
        check("R8 first addr", 32'(cmd_addr), 32'h30010);
        check("R8 first data", 32'(cmd_data), 32'h1111);
        @(negedge clk);
        check("R9 status after word", 32'(read_mode), 32'd2);
        busy = 1'b1;
        wr(22'h30011, 16'h2222);
        check("R11 busy word dropped", 32'(pulses), 32'd0);
        check("R11 seq_err set", 32'(seq_err), 32'd1);
        busy = 1'b0;
        wr(22'h30011, 16'h2222);
        check("R8 next word pulse", 32'(pulses), 32'h20);
        check("R8 next flag", 32'(mwp_first), 32'd0);
        check("R8 next data", 32'(cmd_data), 32'h2222);
        check("R11 seq_err sticky", 32'(seq_err), 32'd1);
        wr(22'h40000, 16'h0000);
        check("R8 done pulse", 32'(pulses), 32'h40);
        check("R8 done addr", 32'(cmd_addr), 32'h40000);
        wr(22'h0, 16'h00F0);
        check("R11 reset pulse", 32'(rd_reset_pulse), 32'd1);
        check("R11 seq_err cleared", 32'(seq_err), 32'd0);
        @(negedge clk);
        check("R12 pulse one cycle", 32'(pulses), 32'd0);

        // R13 reset mid-sequence
        unlock();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wr(22'h555, 16'h00A0);
        wr(22'h100, 16'h0F0F);
        check("R13 sequence cleared by reset", 32'(pulses), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule